// File: doc/BRIEF.md
# Serial Sync-Mark Detector and Sector Deframer

The block watches a recovered serial bit stream, one bit per `bit_valid` strobe, and finds the start of a recorded data field. It first demands a run of alternating bits long enough to count as a preamble. It then expects the stream to break the alternation in exactly the way the 6-bit mark `100100` does. After a clean mark it packs the following bits into bytes, most significant bit first, for one sector, and then starts hunting for the next field. A mark with a dropped bit, an inserted bit or a one-position shift is reported on `sync_err` and the hunt starts over.

The control is one state machine with five states. IDLE holds while `search_en` is low. IDLE goes to HUNT once `search_en` is high. HUNT counts alternating bits and goes to ARMED when the run reaches the preamble minimum. ARMED watches for the first repeated bit: a repeated 1 (shifted mark) or 64 unbroken alternating bits (window timeout) go back to HUNT with an error, and a repeated 0 goes to TAIL. TAIL collects three more bits: `100` goes to DATA with a sync-found pulse, anything else goes back to HUNT with an error. DATA packs the sector and goes to HUNT with a field-done pulse after the last byte. A low `search_en` forces IDLE from any state.

A good mark is therefore seen from the detector's side as `1,0` continuing the alternation, a repeated `0`, and then `1,0,0`. The preamble that precedes it must end on a 0.

Top module: `sms_sync_detector`

## Requirements
- R1: After reset all five outputs are 0 and nothing is emitted until a field is found.
- R2: While `search_en` is low no bit is taken in and `byte_valid`, `sync_found`, `sync_err` and `field_done` stay 0. Dropping it in the middle of a sector aborts the sector with no further bytes and no `field_done`.
- R3: The comparator is armed only after 16 consecutive alternating bits, the leading `1,0` of the mark counted among them. A repeated bit before that restarts the count and raises nothing.
- R4: Once armed, a repeated 0 followed by the bits 1, 0, 0 is a good mark. `sync_found` pulses for one clock in the cycle after the last mark bit is taken.
- R5: A mark with any one of its six bits dropped, followed by all-ones data, raises one `sync_err` pulse and no `sync_found`.
- R6: A mark with an extra bit inserted inside it (for example `1100100`, `1000100`, `1001100`, `1001010`) raises one `sync_err` pulse and no `sync_found`.
- R7: A mark that follows a preamble ending on a 1 (shifted by one bit) shows as a repeated 1 while armed and raises one `sync_err` pulse.
- R8: If 64 bits after arming all keep alternating, `sync_err` pulses after the 64th of them; 63 such bits raise nothing.
- R9: Data bytes are packed MSB first starting with the first bit after the mark; `byte_valid` is high for exactly one clock per byte.
- R10: After 512 bytes `field_done` pulses once, in the same cycle as the last `byte_valid`, and a new preamble is hunted at once.
- R11: After any sync error the block hunts again and a following good field is found; the bits before the error do not count toward the new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| search_en | input | 1 | Enables the search; low forces IDLE |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | `bit_in` is taken on this clock |
| data_byte | output | 8 | Assembled data byte |
| byte_valid | output | 1 | One-clock strobe for `data_byte` |
| sync_found | output | 1 | One-clock pulse after a good mark |
| sync_err | output | 1 | One-clock pulse for a faulty mark or a window timeout |
| field_done | output | 1 | One-clock pulse with the last byte of a sector |

## Verification
A state machine stuck in HUNT or ARMED after a preamble shows as a missing `sync_found` within one bit of the mark's last bit. An early or late switch to DATA shows as bytes shifted by one or more bit positions from the first byte onward, because the first byte is chosen so that any misalignment or bit reversal changes its value. A byte counter that drifts moves `field_done` off the 512th `byte_valid` at the end of the sector. A wrong tracker reset after an error makes the next field be found too early or not at all.

// File: rtl/sms_pkg.sv
package sms_pkg;
    typedef enum logic [2:0] {
        SMS_IDLE,
        SMS_HUNT,
        SMS_ARMED,
        SMS_TAIL,
        SMS_DATA
    } sms_state_e;

    // bits expected after the repeated 0 that closes the alternation
    localparam int          SMS_TAIL_W   = 3;
    localparam logic [2:0]  SMS_TAIL_PAT = 3'b100;
endpackage

// File: rtl/sms_run_tracker.sv
module sms_run_tracker #(
    parameter int PRE_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    output logic brk,
    output logic arm
);
    localparam int            RW      = $clog2(PRE_MIN + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(PRE_MIN);

    logic          prev_q;
    logic          have_q;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_d;

    always_comb begin
        brk = stb && have_q && (bit_in == prev_q);
        if (!have_q || (bit_in == prev_q)) begin
            run_d = RW'(1);
        end else if (run_q == RUN_TOP) begin
            run_d = RUN_TOP;
        end else begin
            run_d = run_q + RW'(1);
        end
        arm = stb && (run_d == RUN_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            run_q  <= '0;
        end else if (clr) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            run_q  <= '0;
        end else if (stb) begin
            prev_q <= bit_in;
            have_q <= 1'b1;
            run_q  <= run_d;
        end
    end
endmodule

// File: rtl/sms_tail_check.sv
module sms_tail_check #(
    parameter int               TAIL_W   = 3,
    parameter logic [TAIL_W-1:0] TAIL_PAT = 3'b100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stb,
    input  logic bit_in,
    output logic done,
    output logic good
);
    localparam int            SW = TAIL_W - 1;
    localparam int            CW = $clog2(TAIL_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(TAIL_W - 1);

    logic [SW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [SW:0]   cat;

    always_comb begin
        cat  = {sh_q, bit_in};
        done = stb && (cnt_q == CNT_LAST);
        good = (cat == TAIL_PAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (stb) begin
            sh_q  <= cat[SW-1:0];
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/sms_byte_packer.sv
module sms_byte_packer #(
    parameter int BYTES  = 512,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stb,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_stb_q,
    output logic              last_bit
);
    localparam int            BCW       = $clog2(BYTE_W);
    localparam int            NCW       = $clog2(BYTES);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);
    localparam logic [NCW-1:0] BYTE_LAST = NCW'(BYTES - 1);

    logic [BYTE_W-2:0] sh_q;
    logic [BYTE_W-1:0] cat;
    logic [BCW-1:0]    bit_cnt_q;
    logic [NCW-1:0]    byte_cnt_q;
    logic              byte_end;

    always_comb begin
        cat      = {sh_q, bit_in};
        byte_end = stb && (bit_cnt_q == BIT_LAST);
        last_bit = byte_end && (byte_cnt_q == BYTE_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            byte_q     <= '0;
            byte_stb_q <= 1'b0;
        end else begin
            byte_stb_q <= 1'b0;
            if (start) begin
                bit_cnt_q  <= '0;
                byte_cnt_q <= '0;
            end else if (stb) begin
                sh_q <= cat[BYTE_W-2:0];
                if (byte_end) begin
                    byte_q     <= cat;
                    byte_stb_q <= 1'b1;
                    bit_cnt_q  <= '0;
                    byte_cnt_q <= last_bit ? '0 : byte_cnt_q + NCW'(1);
                end else begin
                    bit_cnt_q <= bit_cnt_q + BCW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sms_sync_detector.sv
module sms_sync_detector #(
    parameter int PRE_MIN      = 16,
    parameter int SEARCH_BITS  = 64,
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              search_en,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic [BYTE_W-1:0] data_byte,
    output logic              byte_valid,
    output logic              sync_found,
    output logic              sync_err,
    output logic              field_done
);
    import sms_pkg::*;

    localparam int            WW       = $clog2(SEARCH_BITS + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(SEARCH_BITS - 1);

    sms_state_e    state_q, nxt;
    logic          stb;
    logic          brk, arm;
    logic          tail_done, tail_good;
    logic          last_bit;
    logic          timeout;
    logic          ev_found, ev_err, ev_done;
    logic          trk_clr;
    logic [WW-1:0] win_q;

    assign stb     = bit_valid && search_en;
    assign trk_clr = (state_q == SMS_IDLE) || !search_en || ev_err || ev_done;
    assign timeout = (state_q == SMS_ARMED) && stb && !brk && (win_q == WIN_LAST);

    sms_run_tracker #(.PRE_MIN(PRE_MIN)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (trk_clr),
        .stb    (stb),
        .bit_in (bit_in),
        .brk    (brk),
        .arm    (arm)
    );

    sms_tail_check #(.TAIL_W(SMS_TAIL_W), .TAIL_PAT(SMS_TAIL_PAT)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (state_q != SMS_TAIL),
        .stb    (stb && (state_q == SMS_TAIL)),
        .bit_in (bit_in),
        .done   (tail_done),
        .good   (tail_good)
    );

    sms_byte_packer #(.BYTES(SECTOR_BYTES), .BYTE_W(BYTE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (state_q != SMS_DATA),
        .stb        (stb && (state_q == SMS_DATA)),
        .bit_in     (bit_in),
        .byte_q     (data_byte),
        .byte_stb_q (byte_valid),
        .last_bit   (last_bit)
    );

    // search window timer, runs only while armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (state_q != SMS_ARMED) begin
            win_q <= '0;
        end else if (stb) begin
            win_q <= win_q + WW'(1);
        end
    end

    always_comb begin
        nxt      = state_q;
        ev_found = 1'b0;
        ev_err   = 1'b0;
        ev_done  = 1'b0;
        if (!search_en) begin
            nxt = SMS_IDLE;
        end else begin
            unique case (state_q)
                SMS_IDLE:  nxt = SMS_HUNT;
                SMS_HUNT:  if (arm) nxt = SMS_ARMED;
                SMS_ARMED: begin
                    if (brk) begin
                        if (bit_in) begin
                            ev_err = 1'b1;
                            nxt    = SMS_HUNT;
                        end else begin
                            nxt = SMS_TAIL;
                        end
                    end else if (timeout) begin
                        ev_err = 1'b1;
                        nxt    = SMS_HUNT;
                    end
                end
                SMS_TAIL: begin
                    if (tail_done) begin
                        if (tail_good) begin
                            ev_found = 1'b1;
                            nxt      = SMS_DATA;
                        end else begin
                            ev_err = 1'b1;
                            nxt    = SMS_HUNT;
                        end
                    end
                end
                SMS_DATA: begin
                    if (last_bit) begin
                        ev_done = 1'b1;
                        nxt     = SMS_HUNT;
                    end
                end
                default:   nxt = SMS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SMS_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_found <= 1'b0;
            sync_err   <= 1'b0;
            field_done <= 1'b0;
        end else begin
            sync_found <= ev_found;
            sync_err   <= ev_err;
            field_done <= ev_done;
        end
    end
endmodule

// File: rtl/sms_sync_detector_chk.sv
module sms_sync_detector_chk #(
    parameter int SECTOR_BYTES = 512
) (
    input logic clk,
    input logic rst_n,
    input logic search_en,
    input logic byte_valid,
    input logic sync_found,
    input logic sync_err,
    input logic field_done
);
    localparam int            CW        = $clog2(SECTOR_BYTES + 1);
    localparam logic [CW-1:0] SEEN_LAST = CW'(SECTOR_BYTES - 1);
    localparam logic [CW-1:0] SEEN_TOP  = CW'(SECTOR_BYTES);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_q <= '0;
        else if (sync_found) seen_q <= '0;
        else if (byte_valid) seen_q <= seen_q + CW'(1);
    end

    // R4 R7
    found_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_found, sync_err}));

    // R9
    byte_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R10
    done_on_last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_done |-> (byte_valid && (seen_q == SEEN_LAST)));

    // R10
    sector_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (seen_q < SEEN_TOP));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> !(byte_valid || sync_found || sync_err || field_done));

    // R4
    found_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !sync_found);
endmodule

bind sms_sync_detector sms_sync_detector_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .search_en  (search_en),
    .byte_valid (byte_valid),
    .sync_found (sync_found),
    .sync_err   (sync_err),
    .field_done (field_done)
);

// File: tb/sms_sync_detector_test.sv
`timescale 1ns/1ps
module sms_sync_detector_test;
    localparam int NB = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [7:0] data_byte;
    logic       byte_valid, sync_found, sync_err, field_done;

    always #2.5 clk = ~clk;

    sms_sync_detector uut (
        .clk(clk), .rst_n(rst_n), .search_en(search_en),
        .bit_in(bit_in), .bit_valid(bit_valid),
        .data_byte(data_byte), .byte_valid(byte_valid),
        .sync_found(sync_found), .sync_err(sync_err), .field_done(field_done)
    );

    int n_checks = 0, n_fail = 0;
    int n_found = 0, n_err = 0, n_done = 0, n_bytes = 0;
    int bv_double = 0, done_alone = 0;
    logic prev_bv = 1'b0;
    logic [7:0] got [0:4095];
    logic [7:0] exp_b [0:NB-1];
    bit   sbuf [0:8191];
    int   slen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                got[n_bytes % 4096] = data_byte;
                n_bytes++;
                if (prev_bv) bv_double++;
            end
            prev_bv = byte_valid;
            if (sync_found) n_found++;
            if (sync_err)   n_err++;
            if (field_done) begin
                n_done++;
                if (!byte_valid) done_alone++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    task automatic s_clear(); slen = 0; endtask
    task automatic s_push(input bit b); sbuf[slen] = b; slen++; endtask
    task automatic s_alt(input int n, input bit first);
        for (int i = 0; i < n; i++) s_push(first ^ bit'(i % 2));
    endtask
    task automatic s_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) s_push(v[i]);
    endtask
    task automatic s_mark(); s_bits(16'b100100, 6); endtask
    task automatic s_fill(input int nbytes, input logic [7:0] v);
        for (int k = 0; k < nbytes; k++) s_bits({8'h00, v}, 8);
    endtask
    task automatic s_sector(input int nbytes, input bit fixed_first);
        for (int k = 0; k < nbytes; k++) begin
            exp_b[k] = (k == 0 && fixed_first) ? 8'h1E : 8'($urandom);
            s_bits({8'h00, exp_b[k]}, 8);
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic play();
        for (int i = 0; i < slen; i++) send_bit(sbuf[i]);
        repeat (3) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        search_en = 1'b0;
        repeat (2) @(negedge clk);
        search_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // compares nb received bytes starting at base with exp_b, returns mismatches
    function automatic int byte_mism(input int base, input int nb);
        int m = 0;
        for (int k = 0; k < nb; k++)
            if (got[(base + k) % 4096] !== exp_b[k]) m++;
        return m;
    endfunction

    int f0, e0, d0, b0;
    task automatic snap(); f0 = n_found; e0 = n_err; d0 = n_done; b0 = n_bytes; endtask

    task automatic good_sector(input int pre, input string tag, input bit fixed_first);
        snap();
        s_clear(); s_alt(pre, 1'b1); s_mark(); s_sector(NB, fixed_first);
        play();
        chk(n_found - f0 == 1, {tag, " R4 found"}, n_found - f0, 1);
        chk(n_err - e0 == 0, {tag, " R4 no err"}, n_err - e0, 0);
        chk(n_bytes - b0 == NB, {tag, " R10 byte count"}, n_bytes - b0, NB);
        chk(byte_mism(b0, NB) == 0, {tag, " R9 data"}, byte_mism(b0, NB), 0);
        chk(n_done - d0 == 1, {tag, " R10 done"}, n_done - d0, 1);
    endtask

    task automatic expect_err(input string tag);
        chk(n_err - e0 == 1, {tag, " err"}, n_err - e0, 1);
        chk(n_found - f0 == 0, {tag, " no found"}, n_found - f0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic [6:0] ins [0:3];
        logic [5:0] mk;
        void'($urandom(32'h5EED_0001));
        ins[0] = 7'b1100100; ins[1] = 7'b1000100; ins[2] = 7'b1001100; ins[3] = 7'b1001010;
        mk = 6'b100100;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({byte_valid, sync_found, sync_err, field_done, data_byte} == 12'h0,
            "R1 reset outputs", int'({byte_valid, sync_found, sync_err, field_done}), 0);
        restart();

        // R3 boundary: 14 preamble bits plus the mark's leading 1,0 arm exactly
        good_sector(14, "R3 min preamble", 1'b1);
        chk(got[b0 % 4096] == 8'h1E, "R9 first byte MSB first", got[b0 % 4096], 8'h1E);
        chk(bv_double == 0, "R9 strobe width", bv_double, 0);
        chk(done_alone == 0, "R10 done with last byte", done_alone, 0);

        // R10 back-to-back field without restart
        good_sector(20, "R10 back to back", 1'b0);

        // R3 too short: 12 + 2 = 14 alternating bits
        restart(); snap();
        s_clear(); s_alt(12, 1'b1); s_mark(); s_fill(5, 8'h00); play();
        chk(n_found - f0 == 0 && n_err - e0 == 0, "R3 short preamble silent", n_found - f0 + n_err - e0, 0);

        // R3 break restarts count: 10 alt, repeat 0, 12 alt, mark
        restart(); snap();
        s_clear(); s_alt(10, 1'b1); s_push(1'b0); s_alt(12, 1'b1); s_mark(); s_fill(5, 8'h00); play();
        chk(n_found - f0 == 0 && n_err - e0 == 0, "R3 broken preamble silent", n_found - f0 + n_err - e0, 0);

        // R5 every dropped-bit variant
        for (int d = 0; d < 6; d++) begin
            restart(); snap();
            s_clear(); s_alt(16, 1'b1);
            for (int i = 5; i >= 0; i--) if (5 - i != d) s_push(mk[i]);
            s_fill(2, 8'hFF); play();
            expect_err($sformatf("R5 drop bit %0d", d));
        end

        // R6 inserted-bit variants
        for (int k = 0; k < 4; k++) begin
            restart(); snap();
            s_clear(); s_alt(16, 1'b1); s_bits({9'h0, ins[k]}, 7); s_fill(2, 8'hFF); play();
            expect_err($sformatf("R6 insert %b", ins[k]));
        end

        // R7 shifted marks: preamble ends on 1
        restart(); snap();
        s_clear(); s_alt(16, 1'b0); s_mark(); s_fill(2, 8'hFF); play();
        expect_err("R7 shift even");
        restart(); snap();
        s_clear(); s_alt(17, 1'b1); s_mark(); s_fill(2, 8'hFF); play();
        expect_err("R7 shift odd");

        // R11 after an error a fresh good field is found
        snap();
        s_clear(); s_alt(16, 1'b1); s_mark(); s_fill(2, 8'h55); play();
        chk(n_found - f0 == 1, "R11 found after error", n_found - f0, 1);

        // R8 window timeout
        restart(); snap();
        s_clear(); s_alt(16 + 63, 1'b1); play();
        chk(n_err - e0 == 0, "R8 63 bits no err", n_err - e0, 0);
        s_clear(); s_push(1'b0); play();
        chk(n_err - e0 == 1, "R8 64th bit err", n_err - e0, 1);

        // R2 disabled: nothing taken in
        @(negedge clk); search_en = 1'b0; snap();
        s_clear(); s_alt(16, 1'b1); s_mark(); s_fill(4, 8'hA5); play();
        chk((n_found - f0) + (n_err - e0) + (n_bytes - b0) == 0, "R2 disabled quiet",
            (n_found - f0) + (n_err - e0) + (n_bytes - b0), 0);

        // R2 abort mid-sector
        search_en = 1'b1; repeat (2) @(negedge clk); snap();
        s_clear(); s_alt(16, 1'b1); s_mark(); s_sector(10, 1'b0); play();
        @(negedge clk); search_en = 1'b0;
        s_clear(); s_fill(40, 8'h3C); play();
        chk(n_bytes - b0 == 10, "R2 abort byte count", n_bytes - b0, 10);
        chk(n_done - d0 == 0, "R2 abort no done", n_done - d0, 0);
        chk(byte_mism(b0, 10) == 0, "R9 partial data", byte_mism(b0, 10), 0);

        // random preambles and fault mix
        for (int r = 0; r < 2; r++) begin
            restart();
            good_sector(2 * $urandom_range(7, 20), $sformatf("R4 random %0d", r), 1'b0);
        end
        for (int r = 0; r < 4; r++) begin
            int d = $urandom_range(0, 5);
            restart(); snap();
            s_clear(); s_alt(2 * $urandom_range(8, 20), 1'b1);
            for (int i = 5; i >= 0; i--) if (5 - i != d) s_push(mk[i]);
            s_fill(2, 8'hFF); play();
            expect_err($sformatf("R5 random drop %0d", d));
        end
        chk(bv_double == 0, "R9 strobe width final", bv_double, 0);
        chk(done_alone == 0, "R10 done alignment final", done_alone, 0);

        summary();
        $finish;
    end
endmodule